// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of an 8-bit differential successive-approximation converter. A slow sample clock marks the phases. While it is high, the analog front end tracks the difference between its positive and negative inputs. When it falls, the held difference is resolved one bit at a time on a fast bit clock. The sequencer drives a trial code to the capacitive DAC and reads back a single comparator decision that says whether the held difference lies below the trial level. The first decision tests the sign. The remaining seven build the magnitude from the top bit down.

When all decisions are made, a done flag rises and the finished code is published on a result register. The result is the floor of the differential input in two's complement LSB units, saturated at the code range. Done acts as the valid qualifier of the result stream. There is no ready input and no back-pressure: a consumer must take the result while done is high, and the value stays put until the next completed conversion replaces it. The enable and sample-clock inputs are asynchronous to the bit clock and pass through two-flop synchronisers.

Top module: `sar_seq`

## Requirements
- R1: An active-low asynchronous reset drives trial_code, done and result to zero at once, without waiting for a clock edge.
- R2: With enable low, the sequencer sits idle: trial_code is 0 and done is 0, while result keeps its last value. After enable returns high, no conversion starts until the sample clock has been high and has fallen again.
- R3: While the synchronised sample clock is high, trial_code is 0 and done is 0. The third bit-clock rising edge after the sample clock falls begins the conversion.
- R4: The first decision presents trial_code 0x00. A comparator output of 1 (input below trial level) stores 1 in bit 7, and an output of 0 stores 0.
- R5: For bits 6 down to 0, the bit under test is set to 1 on trial_code for one cycle. On the next edge it is kept when the comparator output is 0 and cleared when it is 1, and the next lower bit is then set.
- R6: done rises on the eleventh bit-clock edge after the sample clock falls, once exactly 8 decisions are made. It stays high until the sample clock rises again or enable goes low, and it falls on the third edge after that.
- R7: result changes only in the cycle in which done rises, and it is then equal to trial_code.
- R8: If the sample clock rises before the eighth decision, the conversion is dropped: done stays low and result keeps its previous value.
- R9: The published result is floor(vp - vn) in two's complement LSB units, clamped to the range -128 to 127 (0x80 to 0x7F).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Fast bit-cycling clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Asynchronous run enable; low forces the idle state |
| smp_clk | input | 1 | Asynchronous sample clock; high = sample, falling edge starts conversion |
| cmp_neg | input | 1 | Comparator decision: 1 when the held difference is below the trial level |
| trial_code | output | 8 | Two's complement code presented to the DAC |
| done | output | 1 | Conversion complete; valid qualifier for result |
| result | output | 8 | Last completed conversion, two's complement |

## Verification
A wrong bit index or a wrong decision polarity changes trial_code within one bit-clock cycle. It also gives a wrong result at the next done, eleven edges after the sample clock falls. An off-by-one in the decision count moves the rise of done by a cycle, and a check at exactly that edge catches it. If the abandon path or the enable-low path does not clear its state, done rises when it should not, or result changes while the sample clock is high. Both show within a dozen cycles of the disturbing input.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2,
    ST_DONE   = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a bundle of asynchronous level signals.
module sar_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else if (s == 0) pipe[s] <= din;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sar_search.sv
`timescale 1ns/1ps
// Phase control and MSB-first search. Working code doubles as the trial code.
module sar_search
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_s,
  input  logic             smp_s,
  input  logic             cmp_neg,
  output logic [WIDTH-1:0] work,
  output logic             done,
  output logic             fin,
  output logic [WIDTH-1:0] fin_code
);
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(WIDTH-1);

  sar_state_e       state;
  logic [IW-1:0]    bit_idx;
  logic             decided;
  logic [WIDTH-1:0] next_work;

  // Sign position stores the comparator output as is; magnitude bits store it inverted.
  always_comb begin
    decided   = (bit_idx == TOP_IDX) ? cmp_neg : ~cmp_neg;
    next_work = work;
    for (int i = 0; i < WIDTH; i++) begin
      if (IW'(i) == bit_idx) next_work[i] = decided;
      if (bit_idx != '0 && IW'(i) == bit_idx - 1'b1) next_work[i] = 1'b1;
    end
  end

  assign fin      = en_s && !smp_s && (state == ST_CONV) && (bit_idx == '0);
  assign fin_code = next_work;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_OFF;
      bit_idx <= TOP_IDX;
      work    <= '0;
      done    <= 1'b0;
    end else if (!en_s) begin
      state   <= ST_OFF;
      bit_idx <= TOP_IDX;
      work    <= '0;
      done    <= 1'b0;
    end else if (smp_s) begin
      state   <= ST_SAMPLE;
      bit_idx <= TOP_IDX;
      work    <= '0;
      done    <= 1'b0;
    end else begin
      case (state)
        ST_SAMPLE: begin
          state   <= ST_CONV;
          bit_idx <= TOP_IDX;
          work    <= '0;
        end
        ST_CONV: begin
          work <= next_work;
          if (bit_idx == '0) begin
            state <= ST_DONE;
            done  <= 1'b1;
          end else begin
            bit_idx <= bit_idx - 1'b1;
          end
        end
        default: ; // OFF waits for a sample phase, DONE holds
      endcase
    end
  end
endmodule

// File: rtl/sar_result.sv
`timescale 1ns/1ps
// Published result register, loaded only on the completing decision.
module sar_result #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
module sar_seq #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_bit,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             smp_clk,
  input  logic             cmp_neg,
  output logic [WIDTH-1:0] trial_code,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  logic [1:0]       ctl_s;
  logic             en_s;
  logic             smp_s;
  logic             fin;
  logic [WIDTH-1:0] fin_code;

  sar_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk_bit),
    .rst_n(rst_n),
    .din  ({enable, smp_clk}),
    .dout (ctl_s)
  );
  assign en_s  = ctl_s[1];
  assign smp_s = ctl_s[0];

  sar_search #(.WIDTH(WIDTH)) u_search (
    .clk     (clk_bit),
    .rst_n   (rst_n),
    .en_s    (en_s),
    .smp_s   (smp_s),
    .cmp_neg (cmp_neg),
    .work    (trial_code),
    .done    (done),
    .fin     (fin),
    .fin_code(fin_code)
  );

  sar_result #(.WIDTH(WIDTH)) u_result (
    .clk  (clk_bit),
    .rst_n(rst_n),
    .load (fin),
    .din  (fin_code),
    .q    (result)
  );
endmodule

// File: rtl/sar_seq_chk.sv
`timescale 1ns/1ps
module sar_seq_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_bit,
  input logic             rst_n,
  input logic             en_s,
  input logic             smp_s,
  input logic [WIDTH-1:0] trial_code,
  input logic             done,
  input logic [WIDTH-1:0] result
);
  a_r2_idle_clears: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !en_s |=> (trial_code == '0) && !done);

  a_r3_sample_clears: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (en_s && smp_s) |=> (trial_code == '0) && !done);

  a_r6_done_holds: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (done && en_s && !smp_s) |=> done);

  a_r7_result_stable: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $rose(done) || $stable(result));

  a_r7_result_matches: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $rose(done) |-> (result == trial_code));

  a_r1_reset_zero: assert property (@(posedge clk_bit)
    !rst_n |-> (trial_code == '0) && !done && (result == '0));
endmodule

bind sar_seq sar_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_bit   (clk_bit),
  .rst_n     (rst_n),
  .en_s      (en_s),
  .smp_s     (smp_s),
  .trial_code(trial_code),
  .done      (done),
  .result    (result)
);

// File: tb/sar_seq_test.sv
`timescale 1ns/1ps
module sar_seq_test;
  logic       clk_bit = 1'b0;
  logic       rst_n   = 1'b0;
  logic       enable  = 1'b0;
  logic       smp_clk = 1'b1;
  logic       cmp_neg;
  logic [7:0] trial_code;
  logic       done;
  logic [7:0] result;
  int         diff4 = 0;   // differential input in quarter-LSB units
  int         n_checks = 0;
  int         n_errors = 0;

  localparam int NVEC = 14;
  localparam int VEC_IN [NVEC] = '{0, 3, 4, -1, -4, -5, 508, 511, -512,
                                   300, -300, 170, 2000, -2000};
  localparam logic [7:0] VEC_EXP [NVEC] = '{8'h00, 8'h00, 8'h01, 8'hFF, 8'hFF,
                                            8'hFE, 8'h7F, 8'h7F, 8'h80, 8'h4B,
                                            8'hB5, 8'h2A, 8'h7F, 8'h80};

  always #4 clk_bit = ~clk_bit;

  // Ideal comparator: below the two's complement trial level.
  always_comb cmp_neg = (diff4 < 4 * int'($signed(trial_code)));

  sar_seq uut (
    .clk_bit   (clk_bit),
    .rst_n     (rst_n),
    .enable    (enable),
    .smp_clk   (smp_clk),
    .cmp_neg   (cmp_neg),
    .trial_code(trial_code),
    .done      (done),
    .result    (result)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start_conv(input int d4);
    diff4   = d4;
    smp_clk = 1'b1;
    repeat (4) @(negedge clk_bit);
    smp_clk = 1'b0;
  endtask

  initial begin
    #1ms;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_bit);
    check("R1 reset trial", trial_code, 8'h00);
    check("R1 reset done", {7'd0, done}, 8'h00);
    check("R1 reset result", result, 8'h00);
    rst_n  = 1'b1;
    enable = 1'b1;
    repeat (5) @(negedge clk_bit);
    check("R3 sampling trial", trial_code, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      start_conv(VEC_IN[i]);
      repeat (10) @(negedge clk_bit);
      check("R6 done not early", {7'd0, done}, 8'h00);
      @(negedge clk_bit);
      check("R6 done on time", {7'd0, done}, 8'h01);
      check("R9 result", result, VEC_EXP[i]);
    end
    repeat (6) @(negedge clk_bit);
    check("R6 done holds", {7'd0, done}, 8'h01);
    check("R7 result holds", result, 8'h80);

    // Trial code trace for +75 LSB (0x4B)
    start_conv(300);
    repeat (3) @(negedge clk_bit);
    check("R4 sign trial zero", trial_code, 8'h00);
    @(negedge clk_bit);
    check("R5 bit6 tentative", trial_code, 8'h40);
    @(negedge clk_bit);
    check("R5 bit6 kept bit5 set", trial_code, 8'h60);
    repeat (6) @(negedge clk_bit);
    check("R5 final code", result, 8'h4B);

    // Sample clock rises: done drops on third edge, result held
    smp_clk = 1'b1;
    repeat (2) @(negedge clk_bit);
    check("R6 done until sync", {7'd0, done}, 8'h01);
    @(negedge clk_bit);
    check("R6 done falls", {7'd0, done}, 8'h00);
    check("R7 result kept in sample", result, 8'h4B);
    check("R3 trial cleared", trial_code, 8'h00);

    // Abandoned conversion
    start_conv(-4);
    repeat (6) @(negedge clk_bit);
    smp_clk = 1'b1;
    repeat (12) @(negedge clk_bit);
    check("R8 no done on abort", {7'd0, done}, 8'h00);
    check("R8 result kept", result, 8'h4B);
    smp_clk = 1'b0;
    repeat (11) @(negedge clk_bit);
    check("R8 recovers", result, 8'hFF);

    // Enable low
    enable = 1'b0;
    repeat (3) @(negedge clk_bit);
    check("R2 done low", {7'd0, done}, 8'h00);
    check("R2 trial zero", trial_code, 8'h00);
    check("R2 result kept", result, 8'hFF);
    enable = 1'b1;
    repeat (14) @(negedge clk_bit);
    check("R2 no conversion without sample", {7'd0, done}, 8'h00);

    // Asynchronous reset mid-conversion
    start_conv(508);
    repeat (6) @(negedge clk_bit);
    rst_n = 1'b0;
    #1;
    check("R1 async trial", trial_code, 8'h00);
    check("R1 async result", result, 8'h00);
    check("R1 async done", {7'd0, done}, 8'h00);
    @(negedge clk_bit);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule